// File: doc/BRIEF.md
# Gang Commit Checkpoint Table

This block lets an out-of-order core retire work in groups instead of one instruction at a time. Rather than keeping every in-flight instruction in a large reorder buffer, the core opens a checkpoint only at chosen instructions, usually a long-latency load or a branch. Each checkpoint remembers the PC that opened it and counts the instructions dispatched under it that have not finished yet. When the oldest checkpoint is closed (a younger one exists) and its count has dropped to zero, all of its instructions retire at once and the slot is reused.

The table is a ring of `NUM_CKPT` slots. Every dispatched instruction is tagged with the slot of the youngest checkpoint (or with the slot being opened in the same cycle). Completion reports carry that tag back. A fault report (misspeculation or exception) names a slot. The table then emits a restore event with that slot's saved PC, frees every younger slot, and reopens the faulting slot with an empty count. Register state and the pipeline itself live elsewhere. The block only emits allocate, commit and restore pulses, plus a full flag that the front end uses as a stall.

Top module: `gang_ckpt_table`

## Requirements
- R1: While reset is high and in the first cycle after it, the alloc, commit and restore pulses are low, full is low and the table holds no live slot.
- R2: An open request while a slot is free takes the slot at the tail. The alloc pulse and that slot index appear one cycle later. Indices advance by one per accepted open and wrap from NUM_CKPT-1 to 0.
- R3: When all NUM_CKPT slots are live, full is high and an open request has no effect: no alloc pulse and no slot taken.
- R4: disp_tag shows the tail slot when an open request is accepted in the same cycle, and otherwise the youngest live slot. An accepted dispatch adds one to that slot's pending count and a completion subtracts one from the tagged slot. A dispatch and a completion on the same slot in one cycle leave its count unchanged.
- R5: The oldest slot commits when it is closed and its count is zero. The commit pulse, with that slot's index and saved PC, appears one cycle after the cycle in which both hold. At most one slot commits per cycle, and the youngest slot never commits.
- R6: A commit and an allocation can happen in the same cycle.
- R7: A fault report on a live slot gives, one cycle later, a restore pulse with that slot's index and saved PC. Every younger slot is freed, the tail moves to the faulting slot plus one, and the faulting slot becomes the youngest with its count cleared.
- R8: Completion and fault reports that name a free slot are ignored.
- R9: In a cycle with an accepted fault report, open requests, dispatches, completions and commits are all held off. A commit held off this way happens in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| open_req | input | 1 | Open a new checkpoint at this instruction |
| open_pc | input | CK_PC_W | PC saved with the new checkpoint |
| disp_valid | input | 1 | One instruction dispatched; it is dropped if nothing is open or an open is refused |
| cmpl_valid | input | 1 | One instruction completed |
| cmpl_tag | input | IDX_W | Slot of the completing instruction |
| fault_valid | input | 1 | Misspeculation or exception report |
| fault_tag | input | IDX_W | Slot of the faulting instruction |
| full | output | 1 | All slots live; open requests are refused |
| disp_tag | output | IDX_W | Slot that a dispatch in this cycle joins |
| alloc_valid | output | 1 | Pulse: a slot was opened |
| alloc_idx | output | IDX_W | Slot opened |
| commit_valid | output | 1 | Pulse: a slot gang-committed |
| commit_idx | output | IDX_W | Slot committed |
| commit_pc | output | CK_PC_W | Saved PC of the committed slot |
| restore_valid | output | 1 | Pulse: roll back to a slot |
| restore_idx | output | IDX_W | Slot rolled back to |
| restore_pc | output | CK_PC_W | Saved PC to restart from |

## Verification
The commit path is driven with several patterns. In one, completions drain a closed slot. In another, the youngest slot drains to zero but must wait for a younger one to open. In a third, a slot opens with no instructions and commits as soon as it closes. The last pairs a commit with an allocation in the same cycle. Together these separate the "closed" condition from the "count is zero" condition. The ring is filled to wrap-around and saturation, and then a rollback is aimed at a middle slot. Later commits of the surviving slots show which counts were cleared and which were kept. Fault and completion reports to free slots, same-cycle dispatch and completion, and a fault that lands on top of a pending commit show that ignored or held-off events leave no trace at the outputs.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

    parameter int CK_PC_W  = 32;
    parameter int CK_CNT_W = 6;

    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_OPEN   = 2'd1,
        SLOT_CLOSED = 2'd2
    } slot_state_e;

    typedef struct packed {
        slot_state_e           state;
        logic [CK_PC_W-1:0]    pc;
        logic [CK_CNT_W-1:0]   cnt;
    } slot_t;

    // pending-count update; a decrement at zero is dropped
    function automatic logic [CK_CNT_W-1:0] next_count(
        input logic [CK_CNT_W-1:0] c,
        input logic                up,
        input logic                down
    );
        logic [CK_CNT_W-1:0] r;
        case ({up, down})
            2'b10:   r = c + 1'b1;
            2'b01:   r = (c == '0) ? c : c - 1'b1;
            default: r = c;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ckpt_slot.sv
module ckpt_slot
    import ckpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               alloc_i,
    input  logic [CK_PC_W-1:0] alloc_pc_i,
    input  logic               close_i,
    input  logic               reopen_i,
    input  logic               squash_i,
    input  logic               release_i,
    input  logic               inc_i,
    input  logic               dec_i,
    output slot_t              slot_o
);

    slot_t cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.state <= SLOT_FREE;
            cur.pc    <= '0;
            cur.cnt   <= '0;
        end else if (squash_i || release_i) begin
            cur.state <= SLOT_FREE;
            cur.cnt   <= '0;
        end else if (reopen_i) begin
            cur.state <= SLOT_OPEN;
            cur.cnt   <= '0;
        end else if (alloc_i) begin
            cur.state <= SLOT_OPEN;
            cur.pc    <= alloc_pc_i;
            cur.cnt   <= inc_i ? CK_CNT_W'(1) : '0;
        end else begin
            if (close_i)
                cur.state <= SLOT_CLOSED;
            cur.cnt <= next_count(cur.cnt, inc_i, dec_i);
        end
    end

    assign slot_o = cur;

    // R2
    alloc_free_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_i |-> (cur.state == SLOT_FREE));

    // R4
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !dec_i && cur.state != SLOT_FREE) |-> (cur.cnt != '1));

endmodule

// File: rtl/ckpt_ring.sv
module ckpt_ring #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             rollback_i,
    input  logic [IDX_W-1:0] rb_idx_i,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] tail_o,
    output logic             full_o,
    output logic             empty_o
);

    localparam int OCC_W = IDX_W + 1;

    logic [IDX_W-1:0] head_q, tail_q;
    logic [OCC_W-1:0] occ_q;
    logic [IDX_W-1:0] rb_age;

    assign rb_age = rb_idx_i - head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else if (rollback_i) begin
            tail_q <= rb_idx_i + 1'b1;
            occ_q  <= {1'b0, rb_age} + 1'b1;
        end else begin
            if (push_i) tail_q <= tail_q + 1'b1;
            if (pop_i)  head_q <= head_q + 1'b1;
            occ_q <= occ_q + OCC_W'(push_i) - OCC_W'(pop_i);
        end
    end

    assign head_o  = head_q;
    assign tail_o  = tail_q;
    assign full_o  = (occ_q == OCC_W'(DEPTH));
    assign empty_o = (occ_q == '0);

    // R3
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ_q <= OCC_W'(DEPTH));

    // R3
    push_full_chk: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full_o);

    // R7
    rb_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        rollback_i |=> (occ_q <= $past(occ_q)) && (occ_q != '0));

endmodule

// File: rtl/gang_ckpt_table.sv
module gang_ckpt_table
    import ckpt_pkg::*;
#(
    parameter int NUM_CKPT = 8,
    parameter int IDX_W    = $clog2(NUM_CKPT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               open_req,
    input  logic [CK_PC_W-1:0] open_pc,
    input  logic               disp_valid,
    input  logic               cmpl_valid,
    input  logic [IDX_W-1:0]   cmpl_tag,
    input  logic               fault_valid,
    input  logic [IDX_W-1:0]   fault_tag,
    output logic               full,
    output logic [IDX_W-1:0]   disp_tag,
    output logic               alloc_valid,
    output logic [IDX_W-1:0]   alloc_idx,
    output logic               commit_valid,
    output logic [IDX_W-1:0]   commit_idx,
    output logic [CK_PC_W-1:0] commit_pc,
    output logic               restore_valid,
    output logic [IDX_W-1:0]   restore_idx,
    output logic [CK_PC_W-1:0] restore_pc
);

    slot_t            slots [NUM_CKPT];
    logic [IDX_W-1:0] head, tail, youngest, f_age;
    logic             ring_full, ring_empty;
    logic             rb_ok, do_open, disp_ok, cmpl_ok, commit_ok;

    logic [NUM_CKPT-1:0] sl_alloc, sl_close, sl_reopen, sl_squash;
    logic [NUM_CKPT-1:0] sl_release, sl_inc, sl_dec, open_vec;

    ckpt_ring #(.DEPTH(NUM_CKPT), .IDX_W(IDX_W)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .push_i     (do_open),
        .pop_i      (commit_ok),
        .rollback_i (rb_ok),
        .rb_idx_i   (fault_tag),
        .head_o     (head),
        .tail_o     (tail),
        .full_o     (ring_full),
        .empty_o    (ring_empty)
    );

    assign youngest  = tail - 1'b1;
    assign f_age     = fault_tag - head;
    assign rb_ok     = fault_valid && (slots[fault_tag].state != SLOT_FREE);
    assign do_open   = open_req && !ring_full && !rb_ok;
    assign disp_tag  = (open_req && !ring_full) ? tail : youngest;
    assign disp_ok   = disp_valid && !rb_ok &&
                       (do_open || (!open_req && !ring_empty));
    assign cmpl_ok   = cmpl_valid && !rb_ok &&
                       (slots[cmpl_tag].state != SLOT_FREE);
    assign commit_ok = !rb_ok && (slots[head].state == SLOT_CLOSED) &&
                       (slots[head].cnt == '0);
    assign full      = ring_full;

    for (genvar i = 0; i < NUM_CKPT; i++) begin : g_slot
        logic [IDX_W-1:0] age;
        logic             live;
        assign age  = IDX_W'(i) - head;
        assign live = (slots[i].state != SLOT_FREE);

        assign sl_alloc[i]   = do_open && (tail == IDX_W'(i));
        assign sl_close[i]   = do_open && !ring_empty && (youngest == IDX_W'(i));
        assign sl_reopen[i]  = rb_ok && (fault_tag == IDX_W'(i));
        assign sl_squash[i]  = rb_ok && live && (age > f_age);
        assign sl_release[i] = commit_ok && (head == IDX_W'(i));
        assign sl_inc[i]     = disp_ok && (disp_tag == IDX_W'(i));
        assign sl_dec[i]     = cmpl_ok && (cmpl_tag == IDX_W'(i));
        assign open_vec[i]   = (slots[i].state == SLOT_OPEN);

        ckpt_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .alloc_i    (sl_alloc[i]),
            .alloc_pc_i (open_pc),
            .close_i    (sl_close[i]),
            .reopen_i   (sl_reopen[i]),
            .squash_i   (sl_squash[i]),
            .release_i  (sl_release[i]),
            .inc_i      (sl_inc[i]),
            .dec_i      (sl_dec[i]),
            .slot_o     (slots[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_valid   <= 1'b0;
            alloc_idx     <= '0;
            commit_valid  <= 1'b0;
            commit_idx    <= '0;
            commit_pc     <= '0;
            restore_valid <= 1'b0;
            restore_idx   <= '0;
            restore_pc    <= '0;
        end else begin
            alloc_valid   <= do_open;
            alloc_idx     <= tail;
            commit_valid  <= commit_ok;
            commit_idx    <= head;
            commit_pc     <= slots[head].pc;
            restore_valid <= rb_ok;
            restore_idx   <= fault_tag;
            restore_pc    <= slots[fault_tag].pc;
        end
    end

    // R9
    commit_restore_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(commit_valid && restore_valid));

    // R5
    single_open_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(open_vec));

    // R7
    restore_cause_chk: assert property (@(posedge clk) disable iff (rst)
        restore_valid |-> $past(fault_valid));

    // R3
    alloc_room_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> !$past(full));

endmodule

// File: tb/test_gang_ckpt_table.sv
`timescale 1ns/1ps
module test_gang_ckpt_table;
    import ckpt_pkg::*;

    localparam int NCK = 8;
    localparam int IW  = 3;
    localparam int NV  = 29;

    typedef struct packed {
        logic op; logic dp; logic cp; logic [2:0] ct; logic fv; logic [2:0] ft;
        logic [12:0] exp_out;
    } vec_t;

    function automatic vec_t mk(int op, int dp, int cp, int ct, int fv, int ft,
                                int ea, int eai, int ec, int eci, int er, int eri, int ef);
        vec_t v;
        v.op = op[0]; v.dp = dp[0]; v.cp = cp[0]; v.ct = ct[2:0];
        v.fv = fv[0]; v.ft = ft[2:0];
        v.exp_out = {ea[0], eai[2:0], ec[0], eci[2:0], er[0], eri[2:0], ef[0]};
        return v;
    endfunction

    // columns: open disp cmpl ctag fault ftag | alloc aidx commit cidx restore ridx full
    localparam vec_t VECS [NV] = '{
        mk(1,1,0,0,0,0, 1,0,0,0,0,0,0),  // R2 first slot
        mk(0,1,0,0,0,0, 0,0,0,0,0,0,0),  // R4 count 2
        mk(0,0,1,0,0,0, 0,0,0,0,0,0,0),  // R4 count 1
        mk(1,1,0,0,0,0, 1,1,0,0,0,0,0),  // R2 slot 1, slot 0 closes
        mk(0,0,1,0,0,0, 0,0,0,0,0,0,0),  // R5 slot 0 drains
        mk(0,0,0,0,0,0, 0,0,1,0,0,0,0),  // R5 commit slot 0
        mk(0,0,1,1,0,0, 0,0,0,0,0,0,0),  // R5 youngest drains
        mk(0,0,0,0,0,0, 0,0,0,0,0,0,0),  // R5 youngest never commits
        mk(1,0,0,0,0,0, 1,2,0,0,0,0,0),  // R2 empty slot 2
        mk(1,1,0,0,0,0, 1,3,1,1,0,0,0),  // R6 commit + alloc
        mk(0,1,0,0,0,0, 0,0,1,2,0,0,0),  // R5 empty slot commits on close
        mk(0,0,1,0,1,5, 0,0,0,0,0,0,0),  // R8 reports to free slots
        mk(1,1,0,0,0,0, 1,4,0,0,0,0,0),  // R2 fill
        mk(1,1,0,0,0,0, 1,5,0,0,0,0,0),
        mk(1,1,0,0,0,0, 1,6,0,0,0,0,0),
        mk(1,1,0,0,0,0, 1,7,0,0,0,0,0),
        mk(1,1,0,0,0,0, 1,0,0,0,0,0,0),  // R2 wrap
        mk(1,1,0,0,0,0, 1,1,0,0,0,0,0),
        mk(1,1,0,0,0,0, 1,2,0,0,0,0,1),  // R3 full
        mk(1,1,0,0,0,0, 0,0,0,0,0,0,1),  // R3 open refused
        mk(0,0,0,0,1,5, 0,0,0,0,1,5,0),  // R7 rollback to slot 5
        mk(1,1,0,0,0,0, 1,6,0,0,0,0,0),  // R7 tail is slot 6
        mk(0,0,1,3,0,0, 0,0,0,0,0,0,0),
        mk(0,0,1,3,0,0, 0,0,0,0,0,0,0),
        mk(0,0,0,0,0,0, 0,0,1,3,0,0,0),  // R5 commit slot 3
        mk(0,0,1,4,0,0, 0,0,0,0,0,0,0),
        mk(0,0,0,0,0,0, 0,0,1,4,0,0,0),
        mk(0,0,0,0,0,0, 0,0,1,5,0,0,0),  // R7 count of slot 5 cleared
        mk(0,0,0,0,0,0, 0,0,0,0,0,0,0)   // R5 slot 6 youngest
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               open_req = 1'b0;
    logic [CK_PC_W-1:0] open_pc = '0;
    logic               disp_valid = 1'b0;
    logic               cmpl_valid = 1'b0;
    logic [IW-1:0]      cmpl_tag = '0;
    logic               fault_valid = 1'b0;
    logic [IW-1:0]      fault_tag = '0;
    logic               full;
    logic [IW-1:0]      disp_tag, alloc_idx, commit_idx, restore_idx;
    logic               alloc_valid, commit_valid, restore_valid;
    logic [CK_PC_W-1:0] commit_pc, restore_pc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gang_ckpt_table #(.NUM_CKPT(NCK)) i_gang_ckpt_table (
        .clk(clk), .rst(rst), .open_req(open_req), .open_pc(open_pc),
        .disp_valid(disp_valid), .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
        .fault_valid(fault_valid), .fault_tag(fault_tag), .full(full),
        .disp_tag(disp_tag), .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
        .commit_valid(commit_valid), .commit_idx(commit_idx), .commit_pc(commit_pc),
        .restore_valid(restore_valid), .restore_idx(restore_idx), .restore_pc(restore_pc)
    );

    function automatic logic [12:0] outs();
        return {alloc_valid, alloc_valid ? alloc_idx : 3'd0,
                commit_valid, commit_valid ? commit_idx : 3'd0,
                restore_valid, restore_valid ? restore_idx : 3'd0, full};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input bit op, input logic [CK_PC_W-1:0] pc, input bit dp,
                         input bit cp, input int ct, input bit fv, input int ft);
        open_req = op; open_pc = pc; disp_valid = dp;
        cmpl_valid = cp; cmpl_tag = ct[IW-1:0]; fault_valid = fv; fault_tag = ft[IW-1:0];
    endtask

    task automatic idle();
        drive(0, '0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 first cycle after reset
        tick();
        chk(outs() == 13'd0, "R1 reset state", 64'(outs()), 64'd0);

        // vector table
        for (int k = 0; k < NV; k++) begin
            drive(VECS[k].op, CK_PC_W'(32'h100 + k * 4), VECS[k].dp, VECS[k].cp,
                  int'(VECS[k].ct), VECS[k].fv, int'(VECS[k].ft));
            tick();
            if (outs() != VECS[k].exp_out)
                $display("FAIL table row %0d (see row tags R2..)", k);
            chk(outs() == VECS[k].exp_out, "R2/R3/R5/R6/R7/R8 table",
                64'(outs()), 64'(VECS[k].exp_out));
        end
        idle();

        // R4 disp_tag selection
        do_reset();
        open_req = 1'b1; #1;
        chk(disp_tag == 3'd0, "R4 tag while opening", 64'(disp_tag), 64'd0);
        tick();
        open_req = 1'b0; #1;
        chk(disp_tag == 3'd0, "R4 tag of youngest", 64'(disp_tag), 64'd0);
        open_req = 1'b1; #1;
        chk(disp_tag == 3'd1, "R4 tag of next slot", 64'(disp_tag), 64'd1);
        idle();

        // R5 and R7 saved PCs
        do_reset();
        drive(1, 32'hA000, 1, 0, 0, 0, 0); tick();
        drive(1, 32'hB000, 1, 0, 0, 0, 0); tick();
        drive(0, '0, 0, 1, 0, 0, 0); tick();
        idle(); tick();
        chk(commit_valid && commit_idx == 3'd0 && commit_pc == 32'hA000,
            "R5 commit pc", 64'(commit_pc), 64'hA000);
        drive(0, '0, 0, 0, 0, 1, 1); tick();
        chk(restore_valid && restore_idx == 3'd1 && restore_pc == 32'hB000,
            "R7 restore pc", 64'(restore_pc), 64'hB000);
        idle();

        // R4 dispatch and completion on one slot in one cycle
        do_reset();
        drive(1, 32'h10, 1, 0, 0, 0, 0); tick();
        drive(0, '0, 1, 1, 0, 0, 0); tick();
        drive(1, 32'h20, 0, 0, 0, 0, 0); tick();
        idle(); tick();
        chk(!commit_valid, "R4 net count kept", 64'(commit_valid), 64'd0);
        drive(0, '0, 0, 1, 0, 0, 0); tick();
        idle(); tick();
        chk(commit_valid && commit_idx == 3'd0, "R4 drained after",
            64'({commit_valid, commit_idx}), 64'({1'b1, 3'd0}));

        // R9 fault holds off a pending commit and other events
        do_reset();
        drive(1, 32'h30, 1, 0, 0, 0, 0); tick();
        drive(1, 32'h40, 1, 0, 0, 0, 0); tick();
        drive(0, '0, 0, 1, 0, 0, 0); tick();
        drive(1, 32'h50, 1, 1, 1, 1, 1); tick();
        chk(restore_valid && !alloc_valid && !commit_valid, "R9 events held",
            64'({restore_valid, alloc_valid, commit_valid}), 64'({3'b100}));
        idle(); tick();
        chk(commit_valid && commit_idx == 3'd0 && !alloc_valid, "R9 commit follows",
            64'({commit_valid, commit_idx}), 64'({1'b1, 3'd0}));
        drive(1, 32'h60, 0, 0, 0, 0, 0); tick();
        chk(alloc_valid && alloc_idx == 3'd2, "R7 tail after rollback",
            64'(alloc_idx), 64'd2);
        idle(); tick();
        chk(commit_valid && commit_idx == 3'd1, "R7 reopened slot count cleared",
            64'({commit_valid, commit_idx}), 64'({1'b1, 3'd1}));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule